// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt inputs into one request line for a processor. It has a small bank of word registers on a plain 32-bit register bus. When hardware capture is on, each input sets a bit in a status register. A parameter mask chooses, input by input, whether that bit is set by a rising edge or by a high level. The status bits are masked by an enable register to give the pending set. The block reports the lowest-numbered pending input as a vector and raises the request output when the output gate is open.

Software uses the bus in four ways. It writes the acknowledge word to clear serviced status bits. It uses the set and clear words to change single enable bits without a read-modify-write. It reads the vector to find the input to service. It programs the two master bits: one gates the request output and the other turns hardware capture on. While capture is off, software may load the status register directly, which is useful for tests and for raising interrupts in software.

Top module: `intc_vectored`

## Requirements
- R1: After an active-low reset, status, enable and master read 0, pending reads 0, the vector word (offset 6) reads 0xFFFFFFFF, and irq_out is low.
- R2: A write to the enable word (offset 2) replaces the enable bits. A write to offset 4 ORs the data into enable. A write to offset 5 clears every enable bit whose data bit is 1.
- R3: A write to offset 3 clears every status bit whose data bit is 1. It leaves the other status bits unchanged.
- R4: A write to the master word (offset 7) stores data bits [1:0] only. Reads return them in bits [1:0] with 0 above. Bit 0 is the output gate and bit 1 is the capture enable.
- R5: A write to the status word (offset 0) loads status only while master bit 1 is 0. While bit 1 is 1 the write is ignored and no status bit falls except through offset 3.
- R6: Offset 1 reads status AND enable. Writes to offsets 1 and 6 change nothing.
- R7: Offset 6 reads the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R8: irq_out is 1 exactly when master bit 0 is 1 and pending is nonzero.
- R9: A level input (mask bit 0) sets its status bit on every cycle it is seen high while capture is on. Its bit therefore sets again right after an acknowledge while the input stays high.
- R10: An edge input (mask bit 1) sets its status bit once per rising edge seen while capture is on. Holding it high does not set the bit again after an acknowledge. A rise that happens while capture is off is lost.
- R11: While master bit 1 is 0, no input activity changes the status register.
- R12: Offsets 3, 4 and 5, and every word offset from 8 upward, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_IRQ | Interrupt inputs, asynchronous to clk |
| bus_wr | input | 1 | Write strobe; one word is written per cycle it is high |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with the full 32 inputs and 32-bit words, so the vector can reach index 31. This also exercises the all-ones empty vector at full width. The edge mask 0x0F0F00FF mixes edge and level inputs in alternating groups. One random input pattern therefore drives both kinds of capture together. This shows that an acknowledge under a held pattern brings back only the level bits. With a 6-bit address, offsets 8 to 15 are decoded and checked to read zero.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Word offsets; software and the checker both depend on these values.
   typedef enum logic [2:0] {
      OFF_STATUS = 3'd0,
      OFF_PEND   = 3'd1,
      OFF_ENABLE = 3'd2,
      OFF_ACK    = 3'd3,
      OFF_SET_EN = 3'd4,
      OFF_CLR_EN = 3'd5,
      OFF_VECTOR = 3'd6,
      OFF_MASTER = 3'd7
   } intc_off_e;

   localparam int unsigned INTC_NUM_WORDS = 8;
   localparam int unsigned INTC_WORD_LSB  = 2;

   // Master word bit positions.
   localparam int unsigned MST_OUT_GATE = 0;
   localparam int unsigned MST_CAPTURE  = 1;

endpackage

// File: rtl/intc_sync_capture.sv
module intc_sync_capture #(
   parameter int unsigned N_IRQ       = 32,
   parameter logic [N_IRQ-1:0] EDGE_MASK = '0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] raw_in,
   output logic [N_IRQ-1:0] cap_evt
);

   logic [N_IRQ-1:0] chain_q [SYNC_STAGES];
   logic [N_IRQ-1:0] sync_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= raw_in;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_lvl = chain_q[SYNC_STAGES-1];

   // Per-input choice of capture kind.
   for (genvar i = 0; i < N_IRQ; i++) begin : g_kind
      if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sync_lvl[i];
         end
         assign cap_evt[i] = sync_lvl[i] & ~prev_q;
      end else begin : g_level
         assign cap_evt[i] = sync_lvl[i];
      end
   end

endmodule

// File: rtl/intc_lowest_first.sv
module intc_lowest_first #(
   parameter int unsigned N_REQ = 32,
   parameter int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   // Scan from the top down so the lowest set bit is the last one kept.
   always_comb begin
      idx = '0;
      for (int i = N_REQ - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/intc_bus_decode.sv
module intc_bus_decode
   import intc_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              in_map,
   output intc_off_e         off,
   output logic [INTC_NUM_WORDS-1:0] wr_hit
);

   localparam int unsigned WORD_W = ADDR_W - INTC_WORD_LSB;

   logic [WORD_W-1:0] word;
   logic [INTC_WORD_LSB-1:0] unused_lsb;

   assign word       = bus_addr[ADDR_W-1:INTC_WORD_LSB];
   assign unused_lsb = bus_addr[INTC_WORD_LSB-1:0];
   assign in_map     = (32'(word) < INTC_NUM_WORDS);
   assign off        = intc_off_e'(word[2:0]);

   for (genvar w = 0; w < INTC_NUM_WORDS; w++) begin : g_hit
      assign wr_hit[w] = bus_wr && in_map && (32'(off) == w);
   end

endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
   import intc_pkg::*;
#(
   parameter int unsigned N_IRQ       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [N_IRQ-1:0] EDGE_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  irq_in,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

   // Elaboration-time parameter checks.
   if (N_IRQ < 1 || N_IRQ > DATA_W) begin : g_bad_nirq
      $error("intc_vectored: N_IRQ must be in 1..DATA_W");
   end
   if (ADDR_W < INTC_WORD_LSB + 3) begin : g_bad_addr
      $error("intc_vectored: ADDR_W too small for eight words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("intc_vectored: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("intc_vectored: DATA_W must hold the master bits");
   end

   logic [N_IRQ-1:0] status_q, status_d;
   logic [N_IRQ-1:0] enable_q, enable_d;
   logic [1:0]       mer_q, mer_d;
   logic [N_IRQ-1:0] cap_evt;
   logic [N_IRQ-1:0] pend;
   logic [N_IRQ-1:0] wdata_n;
   logic [IDX_W-1:0] vec_idx;
   logic             vec_valid;
   logic             in_map;
   intc_off_e        off;
   logic [INTC_NUM_WORDS-1:0] wr_hit;

   assign wdata_n = bus_wdata[N_IRQ-1:0];

   intc_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .in_map  (in_map),
      .off     (off),
      .wr_hit  (wr_hit)
   );

   intc_sync_capture #(
      .N_IRQ      (N_IRQ),
      .EDGE_MASK  (EDGE_MASK),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_in (irq_in),
      .cap_evt(cap_evt)
   );

   // Status: software load, then acknowledge, then hardware capture on top.
   always_comb begin
      status_d = status_q;
      if (wr_hit[OFF_STATUS] && !mer_q[MST_CAPTURE]) status_d = wdata_n;
      if (wr_hit[OFF_ACK])                          status_d = status_d & ~wdata_n;
      if (mer_q[MST_CAPTURE])                       status_d = status_d | cap_evt;
   end

   always_comb begin
      enable_d = enable_q;
      if (wr_hit[OFF_ENABLE]) enable_d = wdata_n;
      if (wr_hit[OFF_SET_EN]) enable_d = enable_q | wdata_n;
      if (wr_hit[OFF_CLR_EN]) enable_d = enable_q & ~wdata_n;
   end

   always_comb begin
      mer_d = mer_q;
      if (wr_hit[OFF_MASTER]) mer_d = bus_wdata[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
         mer_q    <= '0;
      end else begin
         status_q <= status_d;
         enable_q <= enable_d;
         mer_q    <= mer_d;
      end
   end

   assign pend = status_q & enable_q;

   intc_lowest_first #(.N_REQ(N_IRQ), .IDX_W(IDX_W)) u_lowest (
      .req(pend),
      .idx(vec_idx),
      .any(vec_valid)
   );

   assign irq_out = mer_q[MST_OUT_GATE] & vec_valid;

   always_comb begin
      bus_rdata = '0;
      if (in_map) begin
         case (off)
            OFF_STATUS: bus_rdata = DATA_W'(status_q);
            OFF_PEND:   bus_rdata = DATA_W'(pend);
            OFF_ENABLE: bus_rdata = DATA_W'(enable_q);
            OFF_VECTOR: bus_rdata = vec_valid ? DATA_W'(vec_idx) : '1;
            OFF_MASTER: bus_rdata = DATA_W'(mer_q);
            default:    bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/intc_vectored_chk.sv
module intc_vectored_chk #(
   parameter int unsigned N_IRQ  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq_out,
   input logic [N_IRQ-1:0]  status_q,
   input logic [N_IRQ-1:0]  enable_q,
   input logic [1:0]        mer_q,
   input logic [N_IRQ-1:0]  pend,
   input logic [IDX_W-1:0]  vec_idx,
   input logic              vec_valid
);

   logic [ADDR_W-3:0] word;
   logic [1:0]        unused_lsb;
   logic [N_IRQ-1:0]  wd;
   logic [N_IRQ-1:0]  below_idx;

   assign word       = bus_addr[ADDR_W-1:2];
   assign unused_lsb = bus_addr[1:0];
   assign wd         = bus_wdata[N_IRQ-1:0];
   assign below_idx  = ~({N_IRQ{1'b1}} << vec_idx);

   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (mer_q[0] && vec_valid));

   p_vec_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> pend[vec_idx]);

   p_vec_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ((pend & below_idx) == '0));

   p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && 32'(word) == 3 && !mer_q[1]) |=> ((status_q & $past(wd)) == '0));

   p_set_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && 32'(word) == 4) |=> ((enable_q & $past(wd)) == $past(wd)));

   p_clr_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && 32'(word) == 5) |=> ((enable_q & $past(wd)) == '0));

   p_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && 32'(word) == 7) |=> (mer_q == $past(bus_wdata[1:0])));

   p_status_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mer_q[1] && !(bus_wr && 32'(word) == 3))
      |=> ((status_q & $past(status_q)) == $past(status_q)));

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mer_q[1] && !bus_wr) |=> $stable(status_q));

endmodule

bind intc_vectored intc_vectored_chk #(
   .N_IRQ (N_IRQ),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .irq_out  (irq_out),
   .status_q (status_q),
   .enable_q (enable_q),
   .mer_q    (mer_q),
   .pend     (pend),
   .vec_idx  (vec_idx),
   .vec_valid(vec_valid)
);

// File: tb/test_intc_vectored.sv
module test_intc_vectored;

   localparam int unsigned N   = 32;
   localparam logic [31:0] EDGE = 32'h0F0F_00FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   logic        done = 1'b0;

   // Bench model of the software-visible state.
   logic [31:0] m_status = '0;
   logic [31:0] m_enable = '0;
   logic [1:0]  m_mer    = '0;

   always #2.5 clk = ~clk;

   intc_vectored #(
      .N_IRQ    (N),
      .DATA_W   (32),
      .ADDR_W   (6),
      .EDGE_MASK(EDGE)
   ) i_intc_vectored (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq_out  (irq_out)
   );

   function automatic logic [31:0] f_vec(input logic [31:0] p);
      for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
      return 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] f_read(input int off);
      case (off)
         0: return m_status;
         1: return m_status & m_enable;
         2: return m_enable;
         6: return f_vec(m_status & m_enable);
         7: return {30'd0, m_mer};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string f_tag(input int off);
      case (off)
         0: return "R5";
         1: return "R6";
         2: return "R2";
         6: return "R7";
         7: return "R4";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic wr(input int off, input logic [31:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = 6'(off * 4);
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input int off, output logic [31:0] v);
      bus_addr = 6'(off * 4);
      #1;
      v = bus_rdata;
   endtask

   task automatic model_wr(input int off, input logic [31:0] d);
      case (off)
         0: if (!m_mer[1]) m_status = d;
         2: m_enable = d;
         3: m_status = m_status & ~d;
         4: m_enable = m_enable | d;
         5: m_enable = m_enable & ~d;
         7: m_mer = d[1:0];
         default: ;
      endcase
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] pat;
      void'($urandom(32'd1234));

      // R1: reset state
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      rd(0, v); chk("R1 status", v, 32'd0);
      rd(1, v); chk("R1 pend", v, 32'd0);
      rd(2, v); chk("R1 enable", v, 32'd0);
      rd(7, v); chk("R1 master", v, 32'd0);
      rd(6, v); chk("R1 vector", v, 32'hFFFF_FFFF);
      chk("R1 irq_out", {31'd0, irq_out}, 32'd0);

      // Directed vector corners, R7 and R8
      wr(2, 32'hFFFF_FFFF); wr(0, 32'h8000_0000); wr(7, 32'h1);
      @(negedge clk); rd(6, v); chk("R7 vector top", v, 32'd31);
      chk("R8 irq high", {31'd0, irq_out}, 32'd1);
      wr(5, 32'h8000_0000);
      @(negedge clk); rd(6, v); chk("R7 vector empty", v, 32'hFFFF_FFFF);
      chk("R8 irq low", {31'd0, irq_out}, 32'd0);
      wr(6, 32'h5); wr(1, 32'hFFFF_FFFF);
      @(negedge clk); rd(1, v); chk("R6 pend write ignored", v, 32'd0);
      rd(6, v); chk("R6 vector write ignored", v, 32'hFFFF_FFFF);

      // R3 directed acknowledge
      wr(7, 32'h0); wr(0, 32'h0000_F00F); wr(3, 32'h0000_100E);
      @(negedge clk); rd(0, v); chk("R3 ack partial", v, 32'h0000_E001);
      wr(0, 32'h0); wr(2, 32'h0);

      // Level input, R11 then R9
      irq_in[8] = 1'b1;
      wait_cyc(6);
      rd(0, v); chk("R11 level no capture", v, 32'd0);
      wr(7, 32'h2); wait_cyc(5);
      rd(0, v); chk("R9 level captured", v, 32'h0000_0100);
      wr(3, 32'h0000_0100); @(negedge clk);
      rd(0, v); chk("R9 level re-set after ack", v, 32'h0000_0100);
      irq_in[8] = 1'b0; wait_cyc(5); wr(3, 32'h0000_0100); @(negedge clk);
      rd(0, v); chk("R9 level cleared after drop", v, 32'd0);

      // Edge input, R10 and R11
      irq_in[3] = 1'b1; wait_cyc(5);
      rd(0, v); chk("R10 edge captured", v, 32'h0000_0008);
      wr(3, 32'h0000_0008); wait_cyc(5);
      rd(0, v); chk("R10 held edge not re-set", v, 32'd0);
      irq_in[3] = 1'b0; wait_cyc(5);
      wr(7, 32'h0);
      irq_in[3] = 1'b1; wait_cyc(6);
      rd(0, v); chk("R11 edge no capture", v, 32'd0);
      wr(7, 32'h2); wait_cyc(6);
      rd(0, v); chk("R10 edge lost while off", v, 32'd0);
      // R5: status write ignored while capture on
      wr(0, 32'h1234_5678); @(negedge clk);
      rd(0, v); chk("R5 write ignored", v, 32'd0);
      irq_in = '0; wait_cyc(5);

      // Random pattern capture with mixed kinds, R9 and R10
      for (int k = 0; k < 20; k++) begin
         wr(7, 32'h0); wr(0, 32'h0);
         wait_cyc(2);
         wr(7, 32'h2);
         pat = $urandom;
         irq_in = pat;
         wait_cyc(6);
         rd(0, v); chk("R9 R10 pattern capture", v, pat);
         wr(3, 32'hFFFF_FFFF); wait_cyc(5);
         rd(0, v); chk("R10 pattern ack keeps level only", v, pat & ~EDGE);
         irq_in = '0; wait_cyc(5);
      end

      // Constrained random software traffic with inputs quiet
      wr(7, 32'h0); wr(0, 32'h0); wr(2, 32'h0);
      m_status = '0; m_enable = '0; m_mer = '0;
      for (int k = 0; k < 300; k++) begin
         int off;
         logic [31:0] d;
         off = int'($urandom_range(0, 15));
         d = $urandom;
         // bias toward sparse data so the vector spreads over indices
         if ($urandom_range(0, 2) == 0) d = 32'h1 << $urandom_range(0, 31);
         if (off == 7 && $urandom_range(0, 1) == 0) d[1] = 1'b0;
         wr(off, d);
         model_wr(off, d);
         for (int r = 0; r < 16; r++) begin
            rd(r, v);
            chk(f_tag(r), v, f_read(r));
         end
         chk("R8 irq_out", {31'd0, irq_out},
             {31'd0, m_mer[0] && ((m_status & m_enable) != 0)});
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule